// File: doc/BRIEF.md
# Carrier Quadrature NCO with Double-Buffered Tuning

This block is the local oscillator of a digital downconverter. A 32-bit phase accumulator advances once per input sample by the sum of an active tuning word and an externally supplied offset word. A 10-bit phase adjustment is added to the top of the accumulated phase. The top bits of that sum select an angle, and a sine/cosine generator turns the angle into a pair of 18-bit signed quadrature samples for the mixer that follows.

The tuning word and the phase adjustment are double-buffered. Software writes staging registers through a small synchronous register port and commits them to the live registers in one of two ways. It can write one of two commit addresses, one for the tuning word and one for the phase adjustment. It can also use an external sync pulse, which commits both at once when that path is armed. A separate control bit makes every commit also restart the accumulator from zero. Several devices that share one sync line can then start from a common phase.

Top module: `carrier_nco`

## Requirements
- R1: While reset is active and after it is released, all staging registers, live registers, control bits and the accumulator are zero. With zero phase, cos_o is +131071 and sin_o is 0.
- R2: On every rising edge with samp_en_i high, the accumulator grows by (live tuning word + cof_i) mod 2^32. With samp_en_i low, it holds, unless R9 applies.
- R3: The live 10-bit phase adjustment is added mod 1024 to accumulator bits 31:22. The 10-bit result is the angle index, and one step is 360/1024 degrees.
- R4: For angle index k, the outputs are round(131071*sin(2πk/1024)) and round(131071*cos(2πk/1024)), within ±1. They appear 2 clocks after the accumulator and phase values that produced them, and their magnitude never exceeds 131071.
- R5: A write to address 0 loads the tuning staging register with wdata_i[31:0]. A write to address 1 loads the phase staging register with wdata_i[9:0]. Neither write changes the live registers or the outputs.
- R6: A write to address 2 copies the tuning staging value to the live tuning register. A write to address 3 copies the phase staging value to the live phase register. The write data is ignored, and the new value is used from the next cycle.
- R7: A write to address 4 sets the control bits: bit 0 arms the sync path and bit 1 arms clear-on-commit. When the sync path is armed, a cycle with sync_i high copies both staging registers to the live registers on the same edge.
- R8: When the sync path is not armed, sync_i has no effect.
- R9: On an edge where any commit happens (address 2, address 3 or armed sync) and clear-on-commit is armed, the accumulator restarts from zero. It becomes the increment made from the live tuning word in force before that commit if samp_en_i is high, and 0 otherwise.
- R10: Writes to addresses 5, 6 and 7 change nothing.
- R11: The tuning word is two's complement. A negative word, for example 0xCEC4EC4F, turns the phase backwards, so sin_o has the opposite sign to the one produced by 0x313B13B1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_en_i | input | 1 | Input sample strobe; the accumulator steps only when high |
| cof_i | input | 32 | Carrier offset frequency word, added to the tuning word |
| sync_i | input | 1 | External commit pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| sin_o | output | 18 | Signed sine sample |
| cos_o | output | 18 | Signed cosine sample |

## Verification
The assertions watch the register side on every cycle. They check the accumulator step and hold, the zeroing on commit, the copy from staging to live registers on each commit path, and that the live registers stay put when no commit happens. They also check that the outputs stay within full scale.

The waveform itself can only be shown by the bench's scenarios. This covers the exact sine/cosine values, the two-cycle latency, the sideband sign of negative words and the phase-step sizes. A behavioural model predicts both samples each cycle while the scenarios sweep every angle index and vary the commit paths, the sample strobe and the offset word.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_FREQ_STAGE  = 3'd0,
        REG_PHASE_STAGE = 3'd1,
        REG_FREQ_COMMIT = 3'd2,
        REG_PHASE_COMMIT= 3'd3,
        REG_CONTROL     = 3'd4
    } reg_addr_e;

    localparam int CTRL_SYNC_ARM_BIT  = 0;
    localparam int CTRL_CLEAR_ARM_BIT = 1;

endpackage

// File: rtl/nco_ctrl_regs.sv
`timescale 1ns/1ps
module nco_ctrl_regs
    import nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int POFF_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 sync_i,
    output logic [PHASE_W-1:0]   freq_stage_o,
    output logic [PHASE_W-1:0]   freq_live_o,
    output logic [POFF_W-1:0]    poff_stage_o,
    output logic [POFF_W-1:0]    poff_live_o,
    output logic                 sync_arm_o,
    output logic                 clear_arm_o,
    output logic                 commit_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] f_stage;
        logic [PHASE_W-1:0] f_live;
        logic [POFF_W-1:0]  p_stage;
        logic [POFF_W-1:0]  p_live;
        logic               sync_arm;
        logic               clear_arm;
    } regs_t;

    regs_t     st_d, st_q;
    reg_addr_e sel;
    logic      hit_f_commit, hit_p_commit, hit_sync;

    always_comb begin
        st_d         = st_q;
        sel          = reg_addr_e'(addr_i);
        hit_f_commit = wr_i && (sel == REG_FREQ_COMMIT);
        hit_p_commit = wr_i && (sel == REG_PHASE_COMMIT);
        hit_sync     = sync_i && st_q.sync_arm;

        if (wr_i) begin
            case (sel)
                REG_FREQ_STAGE:  st_d.f_stage = wdata_i[PHASE_W-1:0];
                REG_PHASE_STAGE: st_d.p_stage = wdata_i[POFF_W-1:0];
                REG_CONTROL: begin
                    st_d.sync_arm  = wdata_i[CTRL_SYNC_ARM_BIT];
                    st_d.clear_arm = wdata_i[CTRL_CLEAR_ARM_BIT];
                end
                default: ;
            endcase
        end

        if (hit_f_commit || hit_sync) st_d.f_live = st_q.f_stage;
        if (hit_p_commit || hit_sync) st_d.p_live = st_q.p_stage;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign freq_stage_o = st_q.f_stage;
    assign freq_live_o  = st_q.f_live;
    assign poff_stage_o = st_q.p_stage;
    assign poff_live_o  = st_q.p_live;
    assign sync_arm_o   = st_q.sync_arm;
    assign clear_arm_o  = st_q.clear_arm;
    assign commit_o     = hit_f_commit || hit_p_commit || hit_sync;

endmodule

// File: rtl/nco_phase_accum.sv
`timescale 1ns/1ps
module nco_phase_accum #(
    parameter int PHASE_W = 32,
    parameter int POFF_W  = 10,
    parameter int IDX_W   = 10
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                step_en_i,
    input  logic [PHASE_W-1:0]  freq_i,
    input  logic [PHASE_W-1:0]  cof_i,
    input  logic [POFF_W-1:0]   poff_i,
    input  logic                zero_fb_i,
    output logic [PHASE_W-1:0]  acc_o,
    output logic [IDX_W-1:0]    angle_o
);

    localparam int POFF_SHIFT = IDX_W - POFF_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_t;

    acc_t               st_d, st_q;
    logic [PHASE_W-1:0] feedback, increment;
    logic [IDX_W-1:0]   poff_aligned;

    always_comb begin
        feedback     = zero_fb_i ? '0 : st_q.acc;
        increment    = step_en_i ? (freq_i + cof_i) : '0;
        st_d.acc     = feedback + increment;
        poff_aligned = IDX_W'(poff_i) << POFF_SHIFT;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // offset occupies only the top bits, so no carry enters from below
    assign angle_o = st_q.acc[PHASE_W-1 -: IDX_W] + poff_aligned;
    assign acc_o   = st_q.acc;

endmodule

// File: rtl/nco_sincos.sv
`timescale 1ns/1ps
module nco_sincos #(
    parameter int QTR_W = 8,
    parameter int AMP_W = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [QTR_W+1:0]        angle_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);

    localparam int QN    = 1 << QTR_W;
    localparam int MAG_W = AMP_W - 1;
    localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}};
    localparam real  HALF_PI = 1.5707963267948966;

    function automatic logic [MAG_W-1:0] qw_val(input int k);
        real ang;
        ang = HALF_PI * real'(k) / real'(QN);
        return MAG_W'($rtoi(real'(FULL) * $sin(ang) + 0.5));
    endfunction

    logic [MAG_W-1:0] qw_rom [QN];

    for (genvar k = 0; k < QN; k++) begin : g_qw
        localparam logic [MAG_W-1:0] ENTRY = qw_val(k);
        assign qw_rom[k] = ENTRY;
    end

    typedef struct packed {
        logic                    s_neg;
        logic [MAG_W-1:0]        s_mag;
        logic                    c_neg;
        logic [MAG_W-1:0]        c_mag;
        logic signed [AMP_W-1:0] s_out;
        logic signed [AMP_W-1:0] c_out;
    } pipe_t;

    pipe_t            st_d, st_q;
    logic [1:0]       quad_s, quad_c;
    logic [QTR_W-1:0] frac, frac_rev;

    function automatic logic [MAG_W-1:0] fold(input logic odd_quad,
                                              input logic [QTR_W-1:0] f,
                                              input logic [QTR_W-1:0] f_rev,
                                              input logic [MAG_W-1:0] at_f,
                                              input logic [MAG_W-1:0] at_rev);
        if (!odd_quad)     return at_f;
        else if (f == '0)  return FULL;
        else               return at_rev;
        // f_rev only selects the ROM word passed as at_rev
    endfunction

    always_comb begin
        st_d     = st_q;
        quad_s   = angle_i[QTR_W+1:QTR_W];
        quad_c   = quad_s + 2'd1;
        frac     = angle_i[QTR_W-1:0];
        frac_rev = QTR_W'(0) - frac;

        st_d.s_neg = quad_s[1];
        st_d.c_neg = quad_c[1];
        st_d.s_mag = fold(quad_s[0], frac, frac_rev, qw_rom[frac], qw_rom[frac_rev]);
        st_d.c_mag = fold(quad_c[0], frac, frac_rev, qw_rom[frac], qw_rom[frac_rev]);

        st_d.s_out = st_q.s_neg ? -$signed({1'b0, st_q.s_mag}) : $signed({1'b0, st_q.s_mag});
        st_d.c_out = st_q.c_neg ? -$signed({1'b0, st_q.c_mag}) : $signed({1'b0, st_q.c_mag});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.c_mag <= FULL;
            st_q.c_out <= $signed({1'b0, FULL});
        end else begin
            st_q <= st_d;
        end
    end

    assign sin_o = st_q.s_out;
    assign cos_o = st_q.c_out;

endmodule

// File: rtl/carrier_nco.sv
`timescale 1ns/1ps
module carrier_nco
    import nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int POFF_W  = 10,
    parameter int DATA_W  = 32,
    parameter int QTR_W   = 8,
    parameter int AMP_W   = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    samp_en_i,
    input  logic [PHASE_W-1:0]      cof_i,
    input  logic                    sync_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);

    localparam int IDX_W = QTR_W + 2;

    logic [PHASE_W-1:0] freq_stage, freq_live, acc;
    logic [POFF_W-1:0]  poff_stage, poff_live;
    logic               sync_arm, clear_arm, commit;
    logic [IDX_W-1:0]   angle;

    nco_ctrl_regs #(
        .PHASE_W(PHASE_W), .POFF_W(POFF_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .sync_i      (sync_i),
        .freq_stage_o(freq_stage),
        .freq_live_o (freq_live),
        .poff_stage_o(poff_stage),
        .poff_live_o (poff_live),
        .sync_arm_o  (sync_arm),
        .clear_arm_o (clear_arm),
        .commit_o    (commit)
    );

    nco_phase_accum #(
        .PHASE_W(PHASE_W), .POFF_W(POFF_W), .IDX_W(IDX_W)
    ) u_accum (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_en_i(samp_en_i),
        .freq_i   (freq_live),
        .cof_i    (cof_i),
        .poff_i   (poff_live),
        .zero_fb_i(commit && clear_arm),
        .acc_o    (acc),
        .angle_o  (angle)
    );

    nco_sincos #(
        .QTR_W(QTR_W), .AMP_W(AMP_W)
    ) u_wave (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .angle_i(angle),
        .sin_o  (sin_o),
        .cos_o  (cos_o)
    );

endmodule

// File: rtl/nco_checker.sv
`timescale 1ns/1ps
module nco_checker #(
    parameter int PHASE_W = 32,
    parameter int POFF_W  = 10,
    parameter int AMP_W   = 18
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    samp_en_i,
    input logic                    sync_i,
    input logic                    wr_i,
    input logic [2:0]              addr_i,
    input logic [PHASE_W-1:0]      cof_i,
    input logic [PHASE_W-1:0]      freq_stage,
    input logic [PHASE_W-1:0]      freq_live,
    input logic [POFF_W-1:0]       poff_stage,
    input logic [POFF_W-1:0]       poff_live,
    input logic                    sync_arm,
    input logic                    clear_arm,
    input logic                    commit,
    input logic [PHASE_W-1:0]      acc,
    input logic signed [AMP_W-1:0] sin_o,
    input logic signed [AMP_W-1:0] cos_o
);

    localparam int FULL = (1 << (AMP_W - 1)) - 1;

    a_r2_accum_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (samp_en_i && !(commit && clear_arm))
        |=> acc == PHASE_W'($past(acc) + $past(freq_live) + $past(cof_i)));

    a_r2_accum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!samp_en_i && !commit) |=> $stable(acc));

    a_r9_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit && clear_arm && !samp_en_i) |=> acc == '0);

    a_r9_clear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit && clear_arm && samp_en_i)
        |=> acc == PHASE_W'($past(freq_live) + $past(cof_i)));

    a_r6_freq_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd2) |=> freq_live == $past(freq_stage));

    a_r6_phase_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd3) |=> poff_live == $past(poff_stage));

    a_r7_sync_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && sync_arm)
        |=> (freq_live == $past(freq_stage)) && (poff_live == $past(poff_stage)));

    // R5 and R8: live registers move only on a commit
    a_r8_live_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(wr_i && (addr_i == 3'd2 || addr_i == 3'd3)) && !(sync_i && sync_arm))
        |=> $stable(freq_live) && $stable(poff_live));

    a_r4_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sin_o) <= FULL) && (int'(sin_o) >= -FULL) &&
        (int'(cos_o) <= FULL) && (int'(cos_o) >= -FULL));

endmodule

bind carrier_nco nco_checker #(
    .PHASE_W(PHASE_W), .POFF_W(POFF_W), .AMP_W(AMP_W)
) u_nco_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .samp_en_i (samp_en_i),
    .sync_i    (sync_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .cof_i     (cof_i),
    .freq_stage(freq_stage),
    .freq_live (freq_live),
    .poff_stage(poff_stage),
    .poff_live (poff_live),
    .sync_arm  (sync_arm),
    .clear_arm (clear_arm),
    .commit    (commit),
    .acc       (acc),
    .sin_o     (sin_o),
    .cos_o     (cos_o)
);

// File: tb/tb_carrier_nco.sv
`timescale 1ns/1ps
module tb_carrier_nco;

    localparam int  FULL = 131071;
    localparam real TWO_PI = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_ni = 1'b0;
    logic               samp_en_i = 1'b0;
    logic [31:0]        cof_i = '0;
    logic               sync_i = 1'b0;
    logic               wr_i = 1'b0;
    logic [2:0]         addr_i = '0;
    logic [31:0]        wdata_i = '0;
    logic signed [17:0] sin_o, cos_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R1";

    bit [31:0] m_fs, m_fl, m_acc;
    bit [9:0]  m_ps, m_pl;
    bit        m_sarm, m_carm;
    int        m_q[$];

    logic        g_en = 1'b0;
    logic [31:0] g_cof = '0;

    always #2.5 clk = ~clk;

    carrier_nco dut (
        .clk_i(clk), .rst_ni(rst_ni), .samp_en_i(samp_en_i), .cof_i(cof_i),
        .sync_i(sync_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .sin_o(sin_o), .cos_o(cos_o)
    );

    function automatic int ideal(input int k, input bit want_cos);
        real x;
        x = real'(FULL) * (want_cos ? $cos(TWO_PI * real'(k) / 1024.0)
                                    : $sin(TWO_PI * real'(k) / 1024.0));
        return (x >= 0.0) ? int'($floor(x + 0.5)) : -int'($floor(-x + 0.5));
    endfunction

    task automatic compare(input int k);
        int es, ec, ds, dc;
        es = ideal(k, 1'b0);
        ec = ideal(k, 1'b1);
        ds = int'(sin_o) - es;
        dc = int'(cos_o) - ec;
        n_checks++;
        if (ds > 1 || ds < -1 || dc > 1 || dc < -1) begin
            n_fails++;
            $display("FAIL %s: sin/cos actual %0d/%0d expected %0d/%0d (angle %0d)",
                     tag, sin_o, cos_o, es, ec, k);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic tick(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic sy);
        bit commit;
        int k;
        wr_i = wr; addr_i = a; wdata_i = d; sync_i = sy;
        samp_en_i = g_en; cof_i = g_cof;

        k = int'((m_acc >> 22) + 32'(m_pl)) & 1023;
        m_q.push_back(k);
        commit = (wr && (a == 3'd2 || a == 3'd3)) || (sy && m_sarm);
        m_acc = ((commit && m_carm) ? 32'd0 : m_acc) + (g_en ? (m_fl + g_cof) : 32'd0);
        if ((wr && a == 3'd2) || (sy && m_sarm)) m_fl = m_fs;
        if ((wr && a == 3'd3) || (sy && m_sarm)) m_pl = m_ps;
        if (wr && a == 3'd0) m_fs = d;
        if (wr && a == 3'd1) m_ps = d[9:0];
        if (wr && a == 3'd4) begin m_sarm = d[0]; m_carm = d[1]; end

        @(posedge clk);
        @(negedge clk);
        compare(m_q.pop_front());
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        tick(1'b1, a, d, 1'b0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 32'd0, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        m_fs = '0; m_fl = '0; m_acc = '0; m_ps = '0; m_pl = '0;
        m_sarm = 1'b0; m_carm = 1'b0;
        m_q = {0};

        // R1: reset values
        repeat (3) @(negedge clk);
        tag = "R1";
        compare(0);
        rst_ni = 1'b1;
        run(2);

        // R5: staging writes leave the live state and outputs alone
        tag = "R5"; g_en = 1'b1;
        wreg(3'd0, 32'h0100_0000);
        wreg(3'd1, 32'd100);
        run(5);

        // R6: per-register commits, data on the commit write ignored
        tag = "R6";
        wreg(3'd2, 32'hDEAD_BEEF);
        run(8);
        wreg(3'd3, 32'h0000_03FF);
        run(6);

        // R2: strobe gating with a nonzero offset word
        tag = "R2"; g_cof = 32'h0040_0000;
        for (int i = 0; i < 18; i++) begin
            g_en = (i % 3) != 0;
            tick(1'b0, 3'd0, 32'd0, 1'b0);
        end
        g_en = 1'b1; g_cof = '0;

        // R3: phase offsets of 32 steps and -512 steps
        tag = "R3";
        wreg(3'd0, 32'd0); wreg(3'd2, 32'd0);
        wreg(3'd1, 32'd32); wreg(3'd3, 32'd0);
        run(4);
        wreg(3'd1, 32'h0000_0200); wreg(3'd3, 32'd0);
        run(4);

        // R11: positive and negative tuning words
        tag = "R11";
        wreg(3'd1, 32'd0); wreg(3'd3, 32'd0);
        wreg(3'd0, 32'h313B_13B1); wreg(3'd2, 32'd0);
        run(12);
        wreg(3'd0, 32'hCEC4_EC4F); wreg(3'd2, 32'd0);
        run(12);

        // R10: unmapped addresses
        tag = "R10";
        wreg(3'd5, 32'hFFFF_FFFF);
        wreg(3'd6, 32'h1234_5678);
        wreg(3'd7, 32'h0000_0003);
        run(4);

        // R7: armed sync commits both staging registers
        tag = "R7";
        wreg(3'd4, 32'd1);
        wreg(3'd0, 32'h0123_4567);
        wreg(3'd1, 32'd77);
        tick(1'b0, 3'd0, 32'd0, 1'b1);
        run(6);

        // R8: disarmed sync ignored
        tag = "R8";
        wreg(3'd4, 32'd0);
        wreg(3'd0, 32'h7000_0000);
        wreg(3'd1, 32'd500);
        tick(1'b0, 3'd0, 32'd0, 1'b1);
        run(6);

        // R9: clear on every commit path, strobe high and low
        tag = "R9";
        wreg(3'd4, 32'd3);
        run(3);
        tick(1'b0, 3'd0, 32'd0, 1'b1);
        run(3);
        g_en = 1'b0;
        tick(1'b0, 3'd0, 32'd0, 1'b1);
        run(3);
        g_en = 1'b1;
        wreg(3'd0, 32'h0800_0000);
        wreg(3'd2, 32'd0);
        run(3);
        wreg(3'd3, 32'd0);
        run(3);

        // R4: sweep every angle index through all quadrants
        tag = "R4";
        wreg(3'd4, 32'd0);
        wreg(3'd1, 32'd0); wreg(3'd3, 32'd0);
        wreg(3'd0, 32'h0040_0000); wreg(3'd2, 32'd0);
        run(1030);
        wreg(3'd0, 32'h00C0_0000); wreg(3'd2, 32'd0);
        wreg(3'd1, 32'd5); wreg(3'd3, 32'd0);
        run(400);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule